// File: doc/BRIEF.md
# SPI Host Register Front End

This block sits between a byte-wide register bus and the serial shift engine of an SPI host controller. It decodes a small address map that holds a read-only code for the base clock rate and a control register with a divider code and the clock phase and polarity bits. It also holds a status register, a data register that launches one byte exchange per write, and a register that picks one chip-select line by number. The control values, the transmit byte and a one-cycle start pulse go to the shift engine. The engine returns its busy level and the last received byte.

The status register doubles as a hardware semaphore, so that several processors can share one controller. A read of the status register while the controller is free returns the lock bit as 0 and takes the lock in the same access. Later reads see 1 until some agent writes a 1 to that bit. Chip select is chosen by number rather than by a bit mask. Any number outside the populated lines, the value 0xFF among them, leaves every active-low select line high.

Top module: `spi_host_regs`

## Requirements
- R1: After reset the control register reads 0x0F, the select-number register reads 0xFF, every select line is high, the lock bit reads 0 on the first status read and no start pulse is issued.
- R2: A read at offset 0x03 returns the parameter CLK_CODE in bits 3:0 and zeros above; writes to that offset change nothing.
- R3: A write at offset 0x04 stores bits 5:0: bits 3:0 drive the divider-code output, bit 4 drives the phase output and bit 5 drives the polarity output. A read returns those six bits with bits 7:6 as 0.
- R4: A read at offset 0x08 returns the lock in bit 0 and busy in bit 1. If the lock is clear, the read returns bit 0 as 0 and sets the lock. Every later status read returns bit 0 as 1 until the lock is released.
- R5: Writing offset 0x08 with bit 0 at 1 clears the lock. Writing it with bit 0 at 0 leaves the lock unchanged.
- R6: The lock is set only by a status read strobe. Idle cycles and accesses to other offsets leave it clear.
- R7: When busy is 0, a write at offset 0x0C makes the start output high for exactly the next cycle and puts the written byte on the transmit output. Status bit 1 reads 1 from the next cycle until the engine drops its busy input.
- R8: A write at offset 0x0C while status bit 1 is 1 issues no start pulse and leaves the transmit output unchanged.
- R9: A read at offset 0x0C returns the receive byte supplied by the engine.
- R10: Writing n at offset 0x10 drives select line n low and every other line high when n < NUM_CS. For n >= NUM_CS, 0xFF included, all lines are high. A read returns the stored number.
- R11: A read at an unmapped offset returns 0x00.
- R12: Read data is registered: the value appears in the cycle after the read strobe and is held until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| eng_busy | input | 1 | Shift engine is exchanging a byte |
| eng_rx_data | input | 8 | Last byte received by the engine |
| eng_start | output | 1 | One-cycle pulse that launches an exchange |
| eng_tx_data | output | 8 | Byte to transmit |
| eng_div_code | output | 4 | Clock divider code |
| eng_cpha | output | 1 | Clock phase select |
| eng_cpol | output | 1 | Clock idle polarity |
| cs_n | output | NUM_CS | Active-low chip-select lines |

## Verification
A lock set by mistake shows up on the very next status read as bit 0 already at 1. A lock that fails to clear shows up as 1 after a release write. Either way the error is visible one access later, so the bench reads status after idle time, after foreign accesses and after each kind of write. A pending-exchange flag that is wrong shows up in two ways: a second start pulse one cycle after an ignored data write, or a status bit 1 that reads 0 during the gap before the engine raises busy. The bench therefore samples the start pulse on the cycle after each data write and reads status right after launching. A bad select decode shows at once as a wrong pattern on cs_n.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam logic [7:0] OFS_CLK  = 8'h03;
  localparam logic [7:0] OFS_CTRL = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_DATA = 8'h0C;
  localparam logic [7:0] OFS_CSN  = 8'h10;

  localparam logic [5:0] CTRL_RST = 6'h0F;
  localparam logic [7:0] CSN_NONE = 8'hFF;

  typedef struct packed {
    logic clk_code;
    logic ctrl;
    logic stat;
    logic data;
    logic csn;
  } reg_hit_t;
endpackage

// File: rtl/spi_reg_decode.sv
module spi_reg_decode
  import spi_host_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output reg_hit_t          rd_hit,
  output reg_hit_t          wr_hit
);
  reg_hit_t sel;

  always_comb begin
    sel          = '0;
    sel.clk_code = (addr == ADDR_W'(OFS_CLK));
    sel.ctrl     = (addr == ADDR_W'(OFS_CTRL));
    sel.stat     = (addr == ADDR_W'(OFS_STAT));
    sel.data     = (addr == ADDR_W'(OFS_DATA));
    sel.csn      = (addr == ADDR_W'(OFS_CSN));
    rd_hit       = rd ? sel : '0;
    wr_hit       = wr ? sel : '0;
  end
endmodule

// File: rtl/spi_sem.sv
module spi_sem (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd,
  input  logic stat_wr,
  input  logic wbit0,
  output logic lock
);
  logic lock_q, lock_d;

  always_comb begin
    lock_d = lock_q;
    if (stat_wr && wbit0)
      lock_d = 1'b0;
    else if (stat_rd)
      lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  assign lock = lock_q;

  AST_LOCK_SET_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(stat_rd)); // R6

  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wbit0) |=> !lock_q); // R5

  AST_LOCK_HOLD_ZERO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !wbit0 && !stat_rd) |=> $stable(lock_q)); // R5
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  input  logic       eng_busy,
  output logic       eng_start,
  output logic [7:0] eng_tx_data,
  output logic       busy
);
  logic       pend_q, pend_d;
  logic       start_q, start_d;
  logic [7:0] tx_q, tx_d;
  logic       launch;

  assign busy   = pend_q | eng_busy;
  assign launch = data_wr && !busy;

  always_comb begin
    pend_d  = pend_q;
    start_d = launch;
    tx_d    = tx_q;
    if (pend_q && eng_busy) pend_d = 1'b0;
    if (launch) begin
      pend_d = 1'b1;
      tx_d   = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      tx_q    <= 8'h00;
    end else begin
      pend_q  <= pend_d;
      start_q <= start_d;
      if (launch) tx_q <= tx_d;
    end
  end

  assign eng_start   = start_q;
  assign eng_tx_data = tx_q;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R7

  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> (!eng_start && $stable(eng_tx_data))); // R8
endmodule

// File: rtl/spi_cs_sel.sv
module spi_cs_sel
  import spi_host_pkg::*;
#(
  parameter int NUM_CS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        cs_num,
  output logic [NUM_CS-1:0] cs_n
);
  logic [7:0] num_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     num_q <= CSN_NONE;
    else if (wr_en) num_q <= wdata;
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs_n[i] = (num_q != 8'(i));
  end

  assign cs_num = num_q;

  AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R10
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         NUM_CS   = 8,
  parameter logic [3:0] CLK_CODE = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              eng_busy,
  input  logic [7:0]        eng_rx_data,
  output logic              eng_start,
  output logic [7:0]        eng_tx_data,
  output logic [3:0]        eng_div_code,
  output logic              eng_cpha,
  output logic              eng_cpol,
  output logic [NUM_CS-1:0] cs_n
);
  reg_hit_t   rd_hit, wr_hit;
  logic       lock, busy;
  logic [7:0] cs_num;
  logic [5:0] ctrl_q, ctrl_d;
  logic [7:0] rdata_q, rdata_d;

  spi_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .rd_hit(rd_hit), .wr_hit(wr_hit)
  );

  spi_sem u_sem (
    .clk(clk), .rst_n(rst_n),
    .stat_rd(rd_hit.stat), .stat_wr(wr_hit.stat),
    .wbit0(bus_wdata[0]), .lock(lock)
  );

  spi_xfer_ctrl u_xfer (
    .clk(clk), .rst_n(rst_n),
    .data_wr(wr_hit.data), .wdata(bus_wdata),
    .eng_busy(eng_busy), .eng_start(eng_start),
    .eng_tx_data(eng_tx_data), .busy(busy)
  );

  spi_cs_sel #(.NUM_CS(NUM_CS)) u_cs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_hit.csn), .wdata(bus_wdata),
    .cs_num(cs_num), .cs_n(cs_n)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_hit.ctrl) ctrl_d = bus_wdata[5:0];
  end

  always_comb begin
    rdata_d = 8'h00;
    unique case (1'b1)
      rd_hit.clk_code: rdata_d = {4'h0, CLK_CODE};
      rd_hit.ctrl:     rdata_d = {2'b00, ctrl_q};
      rd_hit.stat:     rdata_d = {6'b0, busy, lock};
      rd_hit.data:     rdata_d = eng_rx_data;
      rd_hit.csn:      rdata_d = cs_num;
      default:         rdata_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      rdata_q <= 8'h00;
    end else begin
      ctrl_q <= ctrl_d;
      if (bus_rd) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata    = rdata_q;
  assign eng_div_code = ctrl_q[3:0];
  assign eng_cpha     = ctrl_q[4];
  assign eng_cpol     = ctrl_q[5];

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R12

  AST_CTRL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit.ctrl |=> $stable({eng_cpol, eng_cpha, eng_div_code})); // R3
endmodule

// File: tb/tb_spi_host_regs.sv
module tb_spi_host_regs;
  localparam int NUM_CS = 8;
  localparam logic [3:0] CODE = 4'h2;

  logic clk, rst_n, bus_wr, bus_rd, eng_busy, eng_start, eng_cpha, eng_cpol;
  logic [7:0] bus_addr, bus_wdata, bus_rdata, eng_rx_data, eng_tx_data;
  logic [3:0] eng_div_code;
  logic [NUM_CS-1:0] cs_n;
  int n_chk, n_bad, cnt;
  bit done;

  spi_host_regs #(.ADDR_W(8), .NUM_CS(NUM_CS), .CLK_CODE(CODE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(eng_busy), .eng_rx_data(eng_rx_data), .eng_start(eng_start),
    .eng_tx_data(eng_tx_data), .eng_div_code(eng_div_code),
    .eng_cpha(eng_cpha), .eng_cpol(eng_cpol), .cs_n(cs_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // engine model: busy for 5 cycles after a start, then rx = tx ^ 0xA5
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_busy <= 1'b0; cnt <= 0; eng_rx_data <= 8'h00;
    end else if (eng_start) begin
      eng_busy <= 1'b1; cnt <= 5;
    end else if (eng_busy) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        eng_busy <= 1'b0; eng_rx_data <= eng_tx_data ^ 8'hA5;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 50; i++) begin
      rd(8'h08, s);
      if (!s[1]) break;
    end
    wr(8'h08, 8'h01);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 cs_n", cs_n, {NUM_CS{1'b1}});
    check("R1 start", eng_start, 1'b0);
    rd(8'h04, v); check("R1 ctrl", v, 8'h0F);
    rd(8'h10, v); check("R1 csnum", v, 8'hFF);
    rd(8'h08, v); check("R1 lock", v[0], 1'b0);
    wr(8'h08, 8'h01);
  endtask

  task automatic t_clk_code();
    logic [7:0] v;
    wr(8'h03, 8'hF9);
    rd(8'h03, v); check("R2 code", v, {4'h0, CODE});
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr(8'h04, 8'hE6);
    rd(8'h04, v); check("R3 readback", v, 8'h26);
    check("R3 div", eng_div_code, 4'h6);
    check("R3 cpha", eng_cpha, 1'b0);
    check("R3 cpol", eng_cpol, 1'b1);
    wr(8'h04, 8'h13);
    check("R3 cpha2", {eng_cpol, eng_cpha, eng_div_code}, 6'h13);
  endtask

  task automatic t_lock();
    logic [7:0] v;
    repeat (5) @(negedge clk);
    wr(8'h04, 8'h0F); rd(8'h03, v);
    rd(8'h08, v); check("R6 idle no lock", v[0], 1'b0);
    rd(8'h08, v); check("R4 second read", v[0], 1'b1);
    rd(8'h08, v); check("R4 third read", v[0], 1'b1);
    wr(8'h08, 8'h00);
    rd(8'h08, v); check("R5 zero write", v[0], 1'b1);
    wr(8'h08, 8'h01);
    rd(8'h08, v); check("R5 release", v[0], 1'b0);
    wr(8'h08, 8'h01);
  endtask

  task automatic t_xfer();
    logic [7:0] v;
    wr(8'h0C, 8'h3C);
    check("R7 start", eng_start, 1'b1);
    check("R7 tx", eng_tx_data, 8'h3C);
    @(negedge clk); check("R7 pulse end", eng_start, 1'b0);
    rd(8'h08, v); check("R7 busy", v[1], 1'b1);
    wr(8'h0C, 8'h77);
    check("R8 no start", eng_start, 1'b0);
    check("R8 tx kept", eng_tx_data, 8'h3C);
    wait_idle();
    rd(8'h0C, v); check("R9 rx", v, 8'h3C ^ 8'hA5);
    rd(8'h08, v); check("R7 idle", v[1], 1'b0);
    wr(8'h08, 8'h01);
    // immediate status read right after launch
    wr(8'h0C, 8'h81);
    rd(8'h08, v); check("R7 busy early", v[1], 1'b1);
    wait_idle();
    rd(8'h0C, v); check("R9 rx2", v, 8'h81 ^ 8'hA5);
  endtask

  task automatic t_cs();
    logic [7:0] v;
    wr(8'h10, 8'h03); check("R10 n3", cs_n, 8'hF7);
    wr(8'h10, 8'h07); check("R10 n7", cs_n, 8'h7F);
    wr(8'h10, 8'h00); check("R10 n0", cs_n, 8'hFE);
    wr(8'h10, 8'h08); check("R10 n8", cs_n, 8'hFF);
    rd(8'h10, v); check("R10 readback", v, 8'h08);
    wr(8'h10, 8'h05);
    wr(8'h10, 8'hFF); check("R10 none", cs_n, 8'hFF);
  endtask

  task automatic t_misc();
    logic [7:0] v;
    rd(8'h04, v);
    wr(8'h20, 8'h5A);
    rd(8'h20, v); check("R11 unmapped", v, 8'h00);
    rd(8'h03, v);
    repeat (3) @(negedge clk);
    check("R12 hold", bus_rdata, {4'h0, CODE});
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    bus_addr = 8'h00; bus_wdata = 8'h00; bus_wr = 1'b0; bus_rd = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_clk_code();
    t_ctrl();
    t_lock();
    t_xfer();
    t_cs();
    t_misc();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule